// File: doc/BRIEF.md
# Vectored Programmable Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a host processor. When the host acknowledges, the block returns an interrupt vector. It keeps three eight-bit state words, each with one bit per line:

- **Pending:** requests that wait for acknowledgement.
- **In-service:** requests that have been acknowledged but have not yet been retired.
- **Mask:** lines that are blocked from reaching the host.

Because pending and in-service state are tracked apart, a more urgent request can interrupt a handler that is already running.

The host talks to the block through a small synchronous register port. Through it the host sets the mask, the mode bits (level or edge detection, rotating or fixed priority, automatic retirement) and the vector base, and it issues end-of-interrupt commands. The same port reads back all three state words and the base.

Acknowledge takes two pulses on `ack`:

1. The first pulse freezes the arbitration winner and moves it from pending to in-service.
2. The second pulse presents `base + line` on the vector output for one cycle.

If no request is left to resolve at the first pulse, the block returns the vector for line 7 as a spurious interrupt. In that case it leaves the in-service state untouched.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, pending and in-service are 0, mask is 0xFF, the vector base is 0, the mode is edge detection with fixed priority and normal retirement, and `int_out` and `vec_valid` are 0.
- R2: In edge mode (mode bit 0 = 0), a low-to-high transition on a synchronized line sets its pending bit. The bit stays set after the line drops, until the first acknowledge pulse selects that line.
- R3: In level mode (mode bit 0 = 1), the pending bit follows the synchronized line. If the line drops before the first acknowledge pulse and nothing else is pending, the returned vector is base+7 and in-service bit 7 stays 0.
- R4: A line whose mask bit is 1 never raises `int_out`, but its pending bit remains visible in the pending register. `int_out` is asserted only when an unmasked pending request outranks every in-service bit.
- R5: In fixed priority, line 0 is highest and line 7 is lowest.
- R6: A request that outranks the current in-service line raises `int_out` and can be acknowledged on top of it (nesting). A lower or equal request does not raise `int_out`.
- R7: The first `ack` pulse sets the winner's in-service bit and clears its pending bit. The second `ack` pulse drives `vec_out` = base + line with `vec_valid` high for exactly one cycle.
- R8: Writing 1 to bit 0 at address 3 (non-specific end of interrupt) clears the highest-priority set in-service bit.
- R9: With mode bit 2 = 1 (automatic retirement), the in-service bit set by the first pulse is cleared by the second pulse.
- R10: With mode bit 1 = 1 (rotating priority), a level retired by end of interrupt becomes the lowest priority, and the level after it becomes the highest.
- R11: Register port writes take effect at the clock edge. The write map is: address 0 mask, address 1 mode, address 2 vector base, address 3 command. The read map is: address 0 mask, address 1 pending, address 2 in-service, address 3 vector base. `reg_rdata` shows the addressed word one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| int_out | output | 1 | Interrupt request to host |
| ack | input | 1 | Acknowledge pulse, two per interrupt |
| vec_out | output | 8 | Interrupt vector |
| vec_valid | output | 1 | Vector valid, one cycle |

## Verification
The checker watches the following on every cycle:

- `int_out` is only raised from an unmasked pending request.
- In-service bits appear only after an acknowledge pulse.
- In edge mode, pending bits never vanish without an acknowledge.
- `vec_valid` follows an acknowledge and lasts a single cycle.

Some behaviour depends on sequences that only the directed scenarios set up. These are:

- which line wins under fixed and rotated priority;
- nesting over a running handler;
- which bit end of interrupt retires;
- the spurious vector returned after a level request is withdrawn.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic auto_eoi;
    logic rotate;
    logic level;
  } irq_mode_t;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1, s2, prev, pend;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
        pend <= 1'b0;
      end else begin
        s1   <= irq_in[i];
        s2   <= s1;
        prev <= s2;
        if (level_mode) pend <= s2;
        else            pend <= (pend & ~clr[i]) | (s2 & ~prev);
      end
    end
    assign irr[i] = pend;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] low_ptr,
  output logic         found,
  output logic [W-1:0] idx,
  output logic [W-1:0] rank
);
  // N is a power of two, so W-bit arithmetic wraps modulo N.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] pos;
      pos = low_ptr + W'(1) + W'(k);
      if (!found && req[pos]) begin
        found = 1'b1;
        idx   = pos;
        rank  = W'(k);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic         int_out,
  input  logic         ack,
  output logic [N-1:0] vec_out,
  output logic         vec_valid
);
  import irq_pkg::*;

  irq_mode_t    mode_q;
  logic [N-1:0] mask_q, base_q, isr_q, rdata_q, vec_q;
  logic [W-1:0] ptr_q, sel_q, eff_ptr;
  logic         phase_q, spur_q, int_q, vval_q;

  logic [N-1:0] irr_w, pend_w, irr_clr, isr_set, eoi_clr, auto_clr;
  logic         pfound, ifound, raise, ack_first, ack_second, eoi_cmd;
  logic [W-1:0] pidx, prank, iidx, irank;

  assign eff_ptr = mode_q.rotate ? ptr_q : W'(N - 1);
  assign pend_w  = irr_w & ~mask_q;

  irq_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .level_mode(mode_q.level),
    .irq_in(irq_in), .clr(irr_clr), .irr(irr_w)
  );

  irq_prio_pick #(.N(N)) u_pick_pend (
    .req(pend_w), .low_ptr(eff_ptr), .found(pfound), .idx(pidx), .rank(prank)
  );

  irq_prio_pick #(.N(N)) u_pick_isr (
    .req(isr_q), .low_ptr(eff_ptr), .found(ifound), .idx(iidx), .rank(irank)
  );

  assign raise      = pfound && (!ifound || (prank < irank));
  assign ack_first  = ack && !phase_q;
  assign ack_second = ack && phase_q;
  assign eoi_cmd    = reg_we && (reg_addr == ADDR_CMD) && reg_wdata[0];

  assign isr_set  = (ack_first && raise) ? (N'(1) << pidx) : '0;
  assign irr_clr  = isr_set;
  assign eoi_clr  = (eoi_cmd && ifound) ? (N'(1) << iidx) : '0;
  assign auto_clr = (ack_second && mode_q.auto_eoi && !spur_q) ? (N'(1) << sel_q) : '0;

  // Host register port
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      base_q <= '0;
      mode_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_MASK: mask_q <= reg_wdata;
        ADDR_MODE: mode_q <= irq_mode_t'(reg_wdata[2:0]);
        ADDR_BASE: base_q <= reg_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_addr)
        ADDR_MASK: rdata_q <= mask_q;
        ADDR_MODE: rdata_q <= irr_w;
        ADDR_BASE: rdata_q <= isr_q;
        default:   rdata_q <= base_q;
      endcase
    end
  end

  // In-service state and rotation pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      ptr_q <= W'(N - 1);
    end else begin
      isr_q <= (isr_q & ~eoi_clr & ~auto_clr) | isr_set;
      if (mode_q.rotate) begin
        if (eoi_cmd && ifound)  ptr_q <= iidx;
        else if (|auto_clr)     ptr_q <= sel_q;
      end
    end
  end

  // Acknowledge sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      sel_q   <= '0;
      spur_q  <= 1'b0;
      vec_q   <= '0;
      vval_q  <= 1'b0;
      int_q   <= 1'b0;
    end else begin
      int_q  <= raise;
      vval_q <= 1'b0;
      if (ack) phase_q <= ~phase_q;
      if (ack_first) begin
        sel_q  <= raise ? pidx : W'(N - 1);
        spur_q <= ~raise;
      end
      if (ack_second) begin
        vec_q  <= base_q + N'(sel_q);
        vval_q <= 1'b1;
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign int_out   = int_q;
  assign vec_out   = vec_q;
  assign vec_valid = vval_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ack,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask,
  input logic         level_mode,
  input logic         int_out,
  input logic         vec_valid
);
  // R4: the interrupt output needs an unmasked pending request
  a_r4_int_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(irr & ~mask)));

  // R7: in-service bits appear only after an acknowledge pulse
  a_r7_isr_set_on_ack: assert property (@(posedge clk) disable iff (rst)
    (|(isr & ~$past(isr))) |-> $past(ack));

  // R7: the vector is valid for a single cycle
  a_r7_vec_one_cycle: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R7: the vector follows an acknowledge pulse
  a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack));

  // R2: in edge mode a pending bit only falls on acknowledge
  a_r2_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(level_mode) && (|($past(irr) & ~irr))) |-> $past(ack));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .irr(irr_w), .isr(isr_q), .mask(mask_q),
  .level_mode(mode_q.level), .int_out(int_out), .vec_valid(vec_valid)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       int_out;
  logic       ack = 1'b0;
  logic [7:0] vec_out;
  logic       vec_valid;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_out(int_out), .ack(ack),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_irq(input logic [7:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    repeat (3) @(negedge clk);
    irq_in = irq_in & ~m;
    repeat (6) @(negedge clk);
  endtask

  task automatic ack_first();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ack_second(input string req, input logic [7:0] exp_vec);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check({req, " vec_valid"}, vec_valid, 1);
    check({req, " vec_out"}, vec_out, exp_vec);
    @(negedge clk);
    check("R7 vec_valid one cycle", vec_valid, 0);
    @(negedge clk);
  endtask

  task automatic eoi();
    wr(2'd3, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 int_out", int_out, 0);
    check("R1 vec_valid", vec_valid, 0);
    rd(2'd0, d); check("R1 R11 mask", d, 8'hFF);
    rd(2'd1, d); check("R1 pending", d, 0);
    rd(2'd2, d); check("R1 in-service", d, 0);
    rd(2'd3, d); check("R1 base", d, 0);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    pulse_irq(8'h08);
    rd(2'd1, d); check("R2 pending held after drop", d, 8'h08);
    check("R2 int_out", int_out, 1);
    ack_first();
    rd(2'd2, d); check("R7 in-service set", d, 8'h08);
    rd(2'd1, d); check("R7 pending cleared", d, 0);
    check("R6 int_out low while serviced", int_out, 0);
    ack_second("R7", 8'h43);
    eoi();
    rd(2'd2, d); check("R8 in-service cleared", d, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd0, 8'h10);
    pulse_irq(8'h10);
    check("R4 masked no int_out", int_out, 0);
    rd(2'd1, d); check("R4 masked pending visible", d, 8'h10);
    wr(2'd0, 8'h00);
    check("R4 unmasked int_out", int_out, 1);
    ack_first();
    ack_second("R4", 8'h44);
    eoi();
  endtask

  task automatic t_fixed_nest();
    logic [7:0] d;
    pulse_irq(8'h24);
    ack_first();
    ack_second("R5 line2 beats line5", 8'h42);
    rd(2'd1, d); check("R5 line5 still pending", d, 8'h20);
    check("R6 lower request no int_out", int_out, 0);
    pulse_irq(8'h02);
    check("R6 higher request nests", int_out, 1);
    ack_first();
    ack_second("R6", 8'h41);
    rd(2'd2, d); check("R6 nested in-service", d, 8'h06);
    eoi();
    rd(2'd2, d); check("R8 highest cleared first", d, 8'h04);
    check("R6 line5 still blocked", int_out, 0);
    eoi();
    check("R6 line5 raised after eoi", int_out, 1);
    ack_first();
    ack_second("R5", 8'h45);
    eoi();
  endtask

  task automatic t_level_spurious();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    @(negedge clk); irq_in[6] = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 level int_out", int_out, 1);
    rd(2'd1, d); check("R3 level pending", d, 8'h40);
    irq_in[6] = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd1, d); check("R3 level pending follows", d, 0);
    ack_first();
    rd(2'd2, d); check("R3 spurious no in-service", d, 0);
    ack_second("R3 spurious", 8'h47);
    rd(2'd2, d); check("R3 in-service 7 clear", d, 0);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_auto_eoi();
    logic [7:0] d;
    wr(2'd1, 8'h04);
    pulse_irq(8'h01);
    ack_first();
    rd(2'd2, d); check("R9 in-service after first", d, 8'h01);
    ack_second("R9", 8'h40);
    rd(2'd2, d); check("R9 auto cleared", d, 0);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_rotate();
    logic [7:0] d;
    wr(2'd1, 8'h02);
    pulse_irq(8'h08);
    ack_first();
    ack_second("R10", 8'h43);
    eoi();
    pulse_irq(8'h44);
    ack_first();
    ack_second("R10 line6 wins after rotate", 8'h46);
    check("R10 line2 below line6", int_out, 0);
    eoi();
    check("R10 line2 raised", int_out, 1);
    ack_first();
    ack_second("R10", 8'h42);
    eoi();
    rd(2'd2, d); check("R10 in-service empty", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h00);
    t_edge();
    t_mask();
    t_fixed_nest();
    t_level_spurious();
    t_auto_eoi();
    t_rotate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule